// File: doc/BRIEF.md
# Byte-Serial Instruction Field Decoder

This block takes the bytes of a 16-bit segmented machine instruction one per clock over a valid/ready input handshake. It recognises a small set of forms: MOV and ADD between a register and a register or memory operand, MOV and ADD of an immediate into a register or memory operand, the short MOV of an immediate into a register, and ADD of an immediate into the accumulator. Any number of segment-override prefix bytes may come before the opcode.

While bytes arrive, the decoder works out how many trailing bytes the instruction still owes. That count follows from the opcode form, the addressing byte (including the direct-address case), and the width and sign-extension bits. After the last byte it shows one decoded record. The record holds the operation, the direction/width/sign bits, the three addressing-byte fields, the override segment, the displacement and immediate in little-endian order, and the total length. The record stays up until a consumer takes it, and no input is taken meanwhile. Opcodes outside the set, and immediate forms with a wrong sub-field, give an error record.

Top module: `instr_field_decoder`

## Requirements
- R1: A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. While `rec_valid` is high, `in_ready` is low and all record fields hold until a rising edge with `rec_ready` high. The next cycle `rec_valid` is low and `in_ready` is high.
- R2: Prefix bytes 26h, 2Eh, 36h and 3Eh set `rec_seg` to 1 (ES), 2 (CS), 3 (SS) and 4 (DS). With no prefix `rec_seg` is 0. When several prefixes come, the last one wins.
- R3: Opcode 100010DW decodes as op 0 (MOV reg/mem) and 000000DW as op 1 (ADD reg/mem). `rec_d` is opcode bit 1 and `rec_w` is bit 0. The next byte gives `rec_mod` from bits 7:6, `rec_reg` from bits 5:3 and `rec_rm` from bits 2:0.
- R4: The displacement byte count is 0 for mod 00, 1 for mod 01, 2 for mod 10 and 0 for mod 11. The exception is mod 00 with rm 110, which takes 2. A one-byte displacement is sign-extended to 16 bits. Two bytes come low byte first.
- R5: Opcode 1100011W decodes as op 2. After the addressing byte and any displacement it reads a 1-byte (W=0) or 2-byte (W=1) immediate.
- R6: Opcode 100000SW decodes as op 3, with `rec_s` = bit 1. The immediate is 2 bytes when S=0 and W=1, and 1 byte otherwise. When S=1 and W=1 the one byte is sign-extended.
- R7: Opcode 1011WREG decodes as op 4, with no addressing byte. `rec_w` is bit 3, `rec_reg` is bits 2:0, and the immediate is 1 or 2 bytes by W.
- R8: Opcode 0000010W decodes as op 5 with no addressing byte. The immediate is 1 or 2 bytes by W.
- R9: An immediate of one byte that is not sign-extended carries 00h in its upper byte.
- R10: `rec_len` counts every byte of the instruction, prefixes included. Fields that a form does not carry read zero.
- R11: An opcode outside the set, or op 2 or op 3 with a nonzero `reg` sub-field, produces a record with `rec_err`=1 and `rec_op`=7. Its length counts the bytes taken so far. After it is taken, decoding starts again at a fresh instruction.
- R12: After reset `in_ready` is high and `rec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| rec_valid | output | 1 | Decoded record present |
| rec_ready | input | 1 | Consumer takes the record |
| rec_op | output | 3 | Operation code (0..5, 7 = error) |
| rec_d | output | 1 | Direction bit |
| rec_w | output | 1 | Width bit |
| rec_s | output | 1 | Sign-extension bit |
| rec_mod | output | 2 | Addressing-mode field |
| rec_reg | output | 3 | Register field |
| rec_rm | output | 3 | Register/memory field |
| rec_seg | output | 3 | Override segment (0 none, 1 ES, 2 CS, 3 SS, 4 DS) |
| rec_disp | output | 16 | Assembled displacement |
| rec_imm | output | 16 | Assembled immediate |
| rec_len | output | 4 | Instruction length in bytes |
| rec_err | output | 1 | Unsupported or malformed instruction |

## Verification
Every record is due in the cycle right after the rising edge that takes its final byte, because the byte counters and field registers feed the outputs directly. For an error record, that final byte is the opcode or the bad addressing byte. The bench drives bytes at falling edges and reads `rec_valid` and the fields at the very next falling edge, without polling, so a late or early record is reported. The release of a record is checked one cycle after the `rec_ready` edge, and so is the return of `in_ready`. A separate scenario keeps the record pending for several cycles with a prefix byte offered, then shows through the next record's segment and length that the prefix was never taken.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    OP_MOV_RM  = 3'd0,
    OP_ADD_RM  = 3'd1,
    OP_MOV_IRM = 3'd2,
    OP_ADD_IRM = 3'd3,
    OP_MOV_IR  = 3'd4,
    OP_ADD_IA  = 3'd5,
    OP_NONE    = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    ST_OPC   = 3'd0,
    ST_MODRM = 3'd1,
    ST_DISP  = 3'd2,
    ST_IMM   = 3'd3,
    ST_OUT   = 3'd4
  } st_e;

  localparam logic [2:0] SEG_NONE = 3'd0;
endpackage

// File: rtl/ifd_rst_sync.sv
module ifd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];
endmodule

// File: rtl/ifd_opclass.sv
module ifd_opclass
  import ifd_pkg::*;
#(
  parameter int NUM_PFX = 4
) (
  input  logic [BYTE_W-1:0] byte_i,
  output logic              is_prefix_o,
  output logic [2:0]        seg_o,
  output op_e               op_o,
  output logic              needs_modrm_o,
  output logic              d_o,
  output logic              w_o,
  output logic              s_o,
  output logic [2:0]        reg_o
);
  logic [NUM_PFX-1:0] hit;

  // override prefixes share the pattern 001ss110, ss picks the segment
  for (genvar g = 0; g < NUM_PFX; g++) begin : g_pfx
    assign hit[g] = (byte_i == {3'b001, 2'(g), 3'b110});
  end

  assign is_prefix_o = |hit;

  always_comb begin
    seg_o = SEG_NONE;
    for (int i = 0; i < NUM_PFX; i++) begin
      if (hit[i]) seg_o = 3'(i + 1);
    end
  end

  always_comb begin
    op_o          = OP_NONE;
    needs_modrm_o = 1'b0;
    d_o           = 1'b0;
    w_o           = 1'b0;
    s_o           = 1'b0;
    reg_o         = 3'd0;
    casez (byte_i)
      8'b100010??: begin
        op_o = OP_MOV_RM; needs_modrm_o = 1'b1; d_o = byte_i[1]; w_o = byte_i[0];
      end
      8'b000000??: begin
        op_o = OP_ADD_RM; needs_modrm_o = 1'b1; d_o = byte_i[1]; w_o = byte_i[0];
      end
      8'b1100011?: begin
        op_o = OP_MOV_IRM; needs_modrm_o = 1'b1; w_o = byte_i[0];
      end
      8'b100000??: begin
        op_o = OP_ADD_IRM; needs_modrm_o = 1'b1; s_o = byte_i[1]; w_o = byte_i[0];
      end
      8'b1011????: begin
        op_o = OP_MOV_IR; w_o = byte_i[3]; reg_o = byte_i[2:0];
      end
      8'b0000010?: begin
        op_o = OP_ADD_IA; w_o = byte_i[0];
      end
      default: op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/ifd_span.sv
module ifd_span (
  input  logic [1:0] mod_i,
  input  logic [2:0] rm_i,
  output logic [1:0] disp_n_o
);
  always_comb begin
    unique case (mod_i)
      2'b00:   disp_n_o = (rm_i == 3'b110) ? 2'd2 : 2'd0;
      2'b01:   disp_n_o = 2'd1;
      2'b10:   disp_n_o = 2'd2;
      default: disp_n_o = 2'd0;
    endcase
  end
endmodule

// File: rtl/ifd_immlen.sv
module ifd_immlen
  import ifd_pkg::*;
(
  input  op_e        op_i,
  input  logic       w_i,
  input  logic       s_i,
  output logic [1:0] imm_n_o,
  output logic       sext_o
);
  always_comb begin
    imm_n_o = 2'd0;
    sext_o  = 1'b0;
    unique case (op_i)
      OP_MOV_IRM, OP_MOV_IR, OP_ADD_IA: imm_n_o = w_i ? 2'd2 : 2'd1;
      OP_ADD_IRM: begin
        imm_n_o = (w_i && !s_i) ? 2'd2 : 2'd1;
        sext_o  = w_i && s_i;
      end
      default: imm_n_o = 2'd0;
    endcase
  end
endmodule

// File: rtl/instr_field_decoder.sv
module instr_field_decoder
  import ifd_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [2:0]        rec_op,
  output logic              rec_d,
  output logic              rec_w,
  output logic              rec_s,
  output logic [1:0]        rec_mod,
  output logic [2:0]        rec_reg,
  output logic [2:0]        rec_rm,
  output logic [2:0]        rec_seg,
  output logic [15:0]       rec_disp,
  output logic [15:0]       rec_imm,
  output logic [LEN_W-1:0]  rec_len,
  output logic              rec_err
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam int HI = WORD_W - 1;

  logic rst_sn;

  st_e              state_q, state_d;
  op_e              op_q, op_d;
  logic             d_q, d_d, w_q, w_d, s_q, s_d;
  logic [1:0]       mod_q, mod_d;
  logic [2:0]       reg_q, reg_d, rm_q, rm_d, seg_q, seg_d;
  logic [HI:0]      disp_q, disp_d, imm_q, imm_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             err_q, err_d;
  logic [1:0]       disp_n_q, disp_n_d, imm_n_q, imm_n_d;
  logic             sext_q, sext_d;
  logic             cnt_q, cnt_d;

  logic       cls_pfx, cls_modrm, cls_d, cls_w, cls_s;
  logic [2:0] cls_seg, cls_reg;
  op_e        cls_op;
  logic [1:0] span_n;
  op_e        il_op;
  logic       il_w, il_s, il_sext;
  logic [1:0] il_n;
  logic       accept, take;

  ifd_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  ifd_opclass #(.NUM_PFX(4)) u_cls (
    .byte_i(in_data), .is_prefix_o(cls_pfx), .seg_o(cls_seg), .op_o(cls_op),
    .needs_modrm_o(cls_modrm), .d_o(cls_d), .w_o(cls_w), .s_o(cls_s), .reg_o(cls_reg)
  );

  ifd_span u_span (.mod_i(in_data[7:6]), .rm_i(in_data[2:0]), .disp_n_o(span_n));

  assign il_op = (state_q == ST_OPC) ? cls_op : op_q;
  assign il_w  = (state_q == ST_OPC) ? cls_w  : w_q;
  assign il_s  = (state_q == ST_OPC) ? cls_s  : s_q;

  ifd_immlen u_imm (.op_i(il_op), .w_i(il_w), .s_i(il_s), .imm_n_o(il_n), .sext_o(il_sext));

  assign in_ready  = (state_q != ST_OUT);
  assign rec_valid = (state_q == ST_OUT);
  assign accept    = in_valid && in_ready;
  assign take      = rec_valid && rec_ready;

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    d_d      = d_q;
    w_d      = w_q;
    s_d      = s_q;
    mod_d    = mod_q;
    reg_d    = reg_q;
    rm_d     = rm_q;
    seg_d    = seg_q;
    disp_d   = disp_q;
    imm_d    = imm_q;
    len_d    = len_q;
    err_d    = err_q;
    disp_n_d = disp_n_q;
    imm_n_d  = imm_n_q;
    sext_d   = sext_q;
    cnt_d    = cnt_q;

    if (accept && len_q != LEN_MAX) len_d = len_q + 1'b1;

    unique case (state_q)
      ST_OPC: if (accept) begin
        if (cls_pfx) begin
          seg_d = cls_seg;
        end else if (cls_op == OP_NONE) begin
          op_d    = OP_NONE;
          err_d   = 1'b1;
          state_d = ST_OUT;
        end else begin
          op_d  = cls_op;
          d_d   = cls_d;
          w_d   = cls_w;
          s_d   = cls_s;
          reg_d = cls_reg;
          cnt_d = 1'b0;
          if (cls_modrm) begin
            state_d = ST_MODRM;
          end else begin
            imm_n_d = il_n;
            sext_d  = il_sext;
            state_d = ST_IMM;
          end
        end
      end
      ST_MODRM: if (accept) begin
        mod_d = in_data[7:6];
        reg_d = in_data[5:3];
        rm_d  = in_data[2:0];
        if ((op_q == OP_MOV_IRM || op_q == OP_ADD_IRM) && in_data[5:3] != 3'd0) begin
          op_d    = OP_NONE;
          err_d   = 1'b1;
          state_d = ST_OUT;
        end else begin
          disp_n_d = span_n;
          imm_n_d  = il_n;
          sext_d   = il_sext;
          cnt_d    = 1'b0;
          if (span_n != 2'd0)    state_d = ST_DISP;
          else if (il_n != 2'd0) state_d = ST_IMM;
          else                   state_d = ST_OUT;
        end
      end
      ST_DISP: if (accept) begin
        if (!cnt_q) disp_d = {{BYTE_W{in_data[BYTE_W-1]}}, in_data};
        else        disp_d[HI:BYTE_W] = in_data;
        if (!cnt_q && disp_n_q == 2'd2) begin
          cnt_d = 1'b1;
        end else begin
          cnt_d   = 1'b0;
          state_d = (imm_n_q != 2'd0) ? ST_IMM : ST_OUT;
        end
      end
      ST_IMM: if (accept) begin
        if (!cnt_q) imm_d = {(sext_q ? {BYTE_W{in_data[BYTE_W-1]}} : {BYTE_W{1'b0}}), in_data};
        else        imm_d[HI:BYTE_W] = in_data;
        if (!cnt_q && imm_n_q == 2'd2) begin
          cnt_d = 1'b1;
        end else begin
          cnt_d   = 1'b0;
          state_d = ST_OUT;
        end
      end
      ST_OUT: if (take) begin
        state_d  = ST_OPC;
        op_d     = OP_NONE;
        d_d      = 1'b0;
        w_d      = 1'b0;
        s_d      = 1'b0;
        mod_d    = 2'd0;
        reg_d    = 3'd0;
        rm_d     = 3'd0;
        seg_d    = SEG_NONE;
        disp_d   = '0;
        imm_d    = '0;
        len_d    = '0;
        err_d    = 1'b0;
        disp_n_d = 2'd0;
        imm_n_d  = 2'd0;
        sext_d   = 1'b0;
        cnt_d    = 1'b0;
      end
      default: state_d = ST_OPC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q  <= ST_OPC;
      op_q     <= OP_NONE;
      d_q      <= 1'b0;
      w_q      <= 1'b0;
      s_q      <= 1'b0;
      mod_q    <= 2'd0;
      reg_q    <= 3'd0;
      rm_q     <= 3'd0;
      seg_q    <= SEG_NONE;
      disp_q   <= '0;
      imm_q    <= '0;
      len_q    <= '0;
      err_q    <= 1'b0;
      disp_n_q <= 2'd0;
      imm_n_q  <= 2'd0;
      sext_q   <= 1'b0;
      cnt_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      op_q     <= op_d;
      d_q      <= d_d;
      w_q      <= w_d;
      s_q      <= s_d;
      mod_q    <= mod_d;
      reg_q    <= reg_d;
      rm_q     <= rm_d;
      seg_q    <= seg_d;
      disp_q   <= disp_d;
      imm_q    <= imm_d;
      len_q    <= len_d;
      err_q    <= err_d;
      disp_n_q <= disp_n_d;
      imm_n_q  <= imm_n_d;
      sext_q   <= sext_d;
      cnt_q    <= cnt_d;
    end
  end

  assign rec_op   = op_q;
  assign rec_d    = d_q;
  assign rec_w    = w_q;
  assign rec_s    = s_q;
  assign rec_mod  = mod_q;
  assign rec_reg  = reg_q;
  assign rec_rm   = rm_q;
  assign rec_seg  = seg_q;
  assign rec_disp = disp_q;
  assign rec_imm  = imm_q;
  assign rec_len  = len_q;
  assign rec_err  = err_q;

  // R1: no byte is taken while a record waits
  p_ready_blocked_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    rec_valid |-> !in_ready);

  // R1: a record not taken stays unchanged
  p_record_held_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_len) && $stable(rec_imm)
      && $stable(rec_disp) && $stable(rec_op));

  // R1: a taken record leaves after one edge
  p_record_drop_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    rec_valid && rec_ready |=> !rec_valid && in_ready);

  // R11: error records carry the error operation
  p_error_op_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    rec_valid && rec_err |-> rec_op == 3'd7);

  // R6: sign-extended short immediates
  p_sext_imm_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    rec_valid && !rec_err && rec_op == 3'd3 && rec_s && rec_w
      |-> rec_imm[15:8] == {8{rec_imm[7]}});

  // R4: one-byte displacement is sign-extended
  p_disp8_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    rec_valid && !rec_err && rec_op <= 3'd3 && rec_mod == 2'b01
      |-> rec_disp[15:8] == {8{rec_disp[7]}});

  // R9: byte immediates have a clear upper byte
  p_byte_imm_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    rec_valid && !rec_err && rec_op >= 3'd2 && rec_op <= 3'd5 && !rec_w
      |-> rec_imm[15:8] == 8'h00);
endmodule

// File: tb/instr_field_decoder_bench.sv
`timescale 1ns/1ps
module instr_field_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic        rec_valid;
  logic        rec_ready;
  logic [2:0]  rec_op;
  logic        rec_d, rec_w, rec_s;
  logic [1:0]  rec_mod;
  logic [2:0]  rec_reg, rec_rm, rec_seg;
  logic [15:0] rec_disp, rec_imm;
  logic [3:0]  rec_len;
  logic        rec_err;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  instr_field_decoder u_instr_field_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_op(rec_op), .rec_d(rec_d), .rec_w(rec_w), .rec_s(rec_s),
    .rec_mod(rec_mod), .rec_reg(rec_reg), .rec_rm(rec_rm), .rec_seg(rec_seg),
    .rec_disp(rec_disp), .rec_imm(rec_imm), .rec_len(rec_len), .rec_err(rec_err)
  );

  task automatic ck(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic release_rec(input string tag);
    rec_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rec_ready = 1'b0;
    ck(!rec_valid && in_ready, {tag, " R1 release"}, {rec_valid, in_ready}, 2'b01);
  endtask

  task automatic expect_rec(input string tag, input logic [2:0] op, input logic d, input logic w,
                            input logic s, input logic [1:0] md, input logic [2:0] rg,
                            input logic [2:0] rm, input logic [2:0] sg, input logic [15:0] dp,
                            input logic [15:0] im, input logic [3:0] ln);
    @(negedge clk);
    in_valid = 1'b0;
    ck(rec_valid == 1'b1, {tag, " R1 due"}, rec_valid, 1);
    ck(rec_err == 1'b0,   {tag, " R11 err"}, rec_err, 0);
    ck(rec_op == op,      {tag, " R3 op"}, rec_op, op);
    ck({rec_d, rec_w, rec_s} == {d, w, s}, {tag, " R3 dws"}, {rec_d, rec_w, rec_s}, {d, w, s});
    ck({rec_mod, rec_reg, rec_rm} == {md, rg, rm}, {tag, " R3 modrm"},
       {rec_mod, rec_reg, rec_rm}, {md, rg, rm});
    ck(rec_seg == sg,     {tag, " R2 seg"}, rec_seg, sg);
    ck(rec_disp == dp,    {tag, " R4 disp"}, rec_disp, dp);
    ck(rec_imm == im,     {tag, " R5 imm"}, rec_imm, im);
    ck(rec_len == ln,     {tag, " R10 len"}, rec_len, ln);
    release_rec(tag);
  endtask

  task automatic expect_err(input string tag, input logic [3:0] ln);
    @(negedge clk);
    in_valid = 1'b0;
    ck(rec_valid && rec_err, {tag, " R11 err due"}, {rec_valid, rec_err}, 2'b11);
    ck(rec_op == 3'd7, {tag, " R11 op"}, rec_op, 7);
    ck(rec_len == ln,  {tag, " R11 len"}, rec_len, ln);
    release_rec(tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; rec_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ck(in_ready && !rec_valid, "R12 reset", {in_ready, rec_valid}, 2'b10);
  endtask

  task automatic t_regmem();
    send(8'h8B); send(8'hC3);
    expect_rec("R3 mov ax,bx", 0, 1, 1, 0, 2'd3, 0, 3, 0, 16'h0, 16'h0, 2);
    send(8'h03); send(8'hC3);
    expect_rec("R3 add ax,bx", 1, 1, 1, 0, 2'd3, 0, 3, 0, 16'h0, 16'h0, 2);
    send(8'h89); send(8'hD8);
    expect_rec("R3 d0 form", 0, 0, 1, 0, 2'd3, 3, 0, 0, 16'h0, 16'h0, 2);
  endtask

  task automatic t_disp();
    send(8'h8B); send(8'h81); send(8'h34); send(8'h12);
    expect_rec("R4 disp16", 0, 1, 1, 0, 2'd2, 0, 1, 0, 16'h1234, 16'h0, 4);
    send(8'h8B); send(8'h41); send(8'h02);
    expect_rec("R4 disp8 pos", 0, 1, 1, 0, 2'd1, 0, 1, 0, 16'h0002, 16'h0, 3);
    send(8'h8B); send(8'h41); send(8'hF0);
    expect_rec("R4 disp8 neg", 0, 1, 1, 0, 2'd1, 0, 1, 0, 16'hFFF0, 16'h0, 3);
    send(8'h8A); send(8'h06); send(8'h00); send(8'h10);
    expect_rec("R4 direct", 0, 1, 0, 0, 2'd0, 0, 6, 0, 16'h1000, 16'h0, 4);
    send(8'h8B); send(8'h07);
    expect_rec("R4 mod00 none", 0, 1, 1, 0, 2'd0, 0, 7, 0, 16'h0, 16'h0, 2);
  endtask

  task automatic t_prefix();
    send(8'h26); send(8'h8B); send(8'h07);
    expect_rec("R2 es", 0, 1, 1, 0, 2'd0, 0, 7, 1, 16'h0, 16'h0, 3);
    send(8'h3E); send(8'h8B); send(8'hC3);
    expect_rec("R2 ds", 0, 1, 1, 0, 2'd3, 0, 3, 4, 16'h0, 16'h0, 3);
    send(8'h36); send(8'h2E); send(8'h8B); send(8'hC3);
    expect_rec("R2 last wins", 0, 1, 1, 0, 2'd3, 0, 3, 2, 16'h0, 16'h0, 4);
  endtask

  task automatic t_mov_imm();
    send(8'hC7); send(8'hC0); send(8'h34); send(8'h12);
    expect_rec("R5 mov rm imm16", 2, 0, 1, 0, 2'd3, 0, 0, 0, 16'h0, 16'h1234, 4);
    send(8'hC6); send(8'h46); send(8'h05); send(8'h7F);
    expect_rec("R5 mov mem imm8", 2, 0, 0, 0, 2'd1, 0, 6, 0, 16'h0005, 16'h007F, 4);
    send(8'hB8); send(8'h34); send(8'h12);
    expect_rec("R7 mov ax imm", 4, 0, 1, 0, 2'd0, 0, 0, 0, 16'h0, 16'h1234, 3);
    send(8'hB3); send(8'hF9);
    expect_rec("R7 R9 mov bl imm", 4, 0, 0, 0, 2'd0, 3, 0, 0, 16'h0, 16'h00F9, 2);
  endtask

  task automatic t_add_imm();
    send(8'h83); send(8'hC3); send(8'hF9);
    expect_rec("R6 sext", 3, 0, 1, 1, 2'd3, 0, 3, 0, 16'h0, 16'hFFF9, 3);
    send(8'h81); send(8'hC3); send(8'h34); send(8'h12);
    expect_rec("R6 imm16", 3, 0, 1, 0, 2'd3, 0, 3, 0, 16'h0, 16'h1234, 4);
    send(8'h80); send(8'hC0); send(8'h80);
    expect_rec("R9 add byte", 3, 0, 0, 0, 2'd3, 0, 0, 0, 16'h0, 16'h0080, 3);
    send(8'h05); send(8'h34); send(8'h12);
    expect_rec("R8 acc word", 5, 0, 1, 0, 2'd0, 0, 0, 0, 16'h0, 16'h1234, 3);
    send(8'h04); send(8'hFF);
    expect_rec("R8 R9 acc byte", 5, 0, 0, 0, 2'd0, 0, 0, 0, 16'h0, 16'h00FF, 2);
  endtask

  task automatic t_errors();
    send(8'hF4);
    expect_err("R11 unknown", 1);
    send(8'h26); send(8'h90);
    expect_err("R11 unknown after prefix", 2);
    send(8'hC7); send(8'hC8);
    expect_err("R11 mov reg field", 2);
    send(8'h81); send(8'hE8);
    expect_err("R11 add reg field", 2);
    send(8'h8B); send(8'hC3);
    expect_rec("R11 recovery", 0, 1, 1, 0, 2'd3, 0, 3, 0, 16'h0, 16'h0, 2);
  endtask

  task automatic t_backpressure();
    send(8'h8B); send(8'hC3);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1;
      in_data  = 8'h26;
      @(negedge clk);
      ck(rec_valid && !in_ready, "R1 pending", {rec_valid, in_ready}, 2'b10);
      ck(rec_len == 4'd2, "R1 held len", rec_len, 2);
    end
    in_valid = 1'b0;
    release_rec("R1 bp");
    send(8'h8B); send(8'hC3);
    expect_rec("R1 prefix ignored", 0, 1, 1, 0, 2'd3, 0, 3, 0, 16'h0, 16'h0, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_regmem();
    t_disp();
    t_prefix();
    t_mov_imm();
    t_add_imm();
    t_errors();
    t_backpressure();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule